// File: doc/BRIEF.md
# Timestamped Action Release Channel

This block holds actions, each made of an execution timestamp and an event, parameter and tag payload, until a free-running time input reaches them. It then presents each action once on an output channel. A set of flags on the output says how the action relates to the present time. The time input advances by one tick of `2**LOG_TICK` units on every clock. A small store of `2**LOG_SLOTS` entries keeps the actions that are waiting.

On each clock edge the block takes at most one new action into the store and presents at most one action at the output. An action is released when it falls inside the current tick, when it is already overdue, or when it lies beyond the scheduling horizon of `2**(LOG_SLOTS+LOG_TICK)` units. An action that has missed its tick is marked delayed. An action whose timestamp repeats the last released timestamp is marked conflict. An action that was already past when it arrived, or that would break time order, is marked late. An action beyond the horizon is marked early. A downstream stall freezes the action on the output until the stall is released.

Top module: `act_release`

## Requirements
- R1: An action sampled at clock edge k is stored and can be presented no earlier than edge k+1. The presented action carries its timestamp, event, parameter and tag unchanged. When no flag is set, every output field reads zero.
- R2: The on-time flag (`out_valid_o`) is set only when the timestamp t and the `now_i` value sampled at the loading edge satisfy now ≤ t < now + 2**LOG_TICK.
- R3: The conflict flag is set only when the timestamp equals that of the most recent action flagged on-time or delayed. Such an action is neither on-time nor delayed.
- R4: An action that becomes due but is released after its tick has passed (t < now, not late) is flagged delayed. Across all on-time and delayed outputs, timestamps rise strictly.
- R5: An action with t < now at arrival is flagged late. So is an action whose timestamp is below the last on-time or delayed timestamp when it is released.
- R6: An action with t ≥ now + 2**(LOG_SLOTS+LOG_TICK) at the loading edge is released at once and flagged early. The output sets at most one of its five flags.
- R7: When all 2**LOG_SLOTS entries are occupied at an edge where `in_valid_i` is high, the new action is dropped. `overflow_o` is then high for exactly the following cycle. Occupancy is judged before that edge's release.
- R8: While any flag is set and `stall_i` is high at an edge, the output keeps all of its fields and flags, and no stored action is consumed.
- R9: An entry is eligible when t < now + 2**LOG_TICK or t ≥ now + 2**(LOG_SLOTS+LOG_TICK). The eligible entry with the smallest timestamp is released first, with ties going to the lower store slot. Every accepted action is released exactly once.
- R10: A synchronous active-high reset empties the store, clears every flag, clears the output fields and clears `overflow_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| now_i | input | 32 | Current time, advancing one tick per clock |
| in_valid_i | input | 1 | A new action is offered this cycle |
| in_stamp_i | input | 32 | Execution timestamp of the offered action |
| in_evt_i | input | 8 | Event field of the offered action |
| in_prm_i | input | 16 | Parameter field of the offered action |
| in_tag_i | input | 8 | Tag field of the offered action |
| stall_i | input | 1 | Downstream cannot accept the presented action |
| out_valid_o | output | 1 | Presented action is inside the current tick |
| out_delayed_o | output | 1 | Presented action missed its tick |
| out_conflict_o | output | 1 | Presented action repeats the previous timestamp |
| out_late_o | output | 1 | Presented action was already overdue or out of order |
| out_early_o | output | 1 | Presented action lies beyond the horizon |
| out_stamp_o | output | 32 | Timestamp of the presented action |
| out_evt_o | output | 8 | Event field of the presented action |
| out_prm_o | output | 16 | Parameter field of the presented action |
| out_tag_o | output | 8 | Tag field of the presented action |
| overflow_o | output | 1 | An offered action was dropped on the previous edge |

## Verification
Two functions can fall on the same edge. First, a stall can freeze the output while another stored action reaches its tick. That action must then appear later flagged delayed, in time order. The bench provokes this directly: it stalls an on-time output while a second action falls due, and the random phase repeats it with stalls on about a quarter of the cycles. Second, an arrival can meet a full store on the same edge as a release. The behavioural queue model judges whether that arrival is dropped from the occupancy before the release, and every output field is compared against the model on every clock.

// File: rtl/act_rel_pkg.sv
package act_rel_pkg;

    localparam int TIME_W = 32;
    localparam int EVT_W  = 8;
    localparam int PRM_W  = 16;
    localparam int TAG_W  = 8;

    typedef logic [TIME_W-1:0] stamp_t;
    typedef logic [TIME_W:0]   wide_t;

    typedef struct packed {
        stamp_t            stamp;
        logic [EVT_W-1:0]  evt;
        logic [PRM_W-1:0]  prm;
        logic [TAG_W-1:0]  tag;
    } action_t;

    typedef enum logic [2:0] {
        K_IDLE, K_ONTIME, K_DELAYED, K_CONFLICT, K_LATE, K_EARLY
    } kind_t;

    function automatic wide_t offset(input stamp_t now, input int unsigned log_span);
        return {1'b0, now} + (wide_t'(1) << log_span);
    endfunction

    // Precedence: out of order / overdue first, then beyond horizon,
    // then repeated stamp, then inside or behind the current tick.
    function automatic kind_t classify(
        input stamp_t stamp, input logic arrived_late, input stamp_t now,
        input wide_t horizon, input logic has_last, input stamp_t last);
        if (arrived_late || (has_last && stamp < last)) return K_LATE;
        if ({1'b0, stamp} >= horizon)                   return K_EARLY;
        if (has_last && stamp == last)                  return K_CONFLICT;
        if (stamp >= now)                               return K_ONTIME;
        return K_DELAYED;
    endfunction

endpackage

// File: rtl/act_store.sv
module act_store
    import act_rel_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  action_t          wr_act,
    input  logic             wr_late,
    input  logic             take,
    input  logic [IDX_W-1:0] take_idx,
    output logic [SLOTS-1:0] used_o,
    output action_t          acts_o [SLOTS],
    output logic [SLOTS-1:0] late_o,
    output logic             full_o
);

    logic [SLOTS-1:0] used_q;
    logic [SLOTS-1:0] late_q;
    action_t          slot_q [SLOTS];
    logic [IDX_W-1:0] free_idx;
    logic             free_found;

    always_comb begin
        free_idx   = '0;
        free_found = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!used_q[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign full_o = &used_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q <= '0;
        end else begin
            if (take)
                used_q[take_idx] <= 1'b0;
            if (wr_en && !full_o)
                used_q[free_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full_o) begin
            slot_q[free_idx] <= wr_act;
            late_q[free_idx] <= wr_late;
        end
    end

    assign used_o = used_q;
    assign late_o = late_q;
    assign acts_o = slot_q;

endmodule

// File: rtl/act_pick.sv
module act_pick
    import act_rel_pkg::*;
#(
    parameter int SLOTS    = 4,
    parameter int IDX_W    = 2,
    parameter int LOG_TICK = 1,
    parameter int LOG_HZ   = 3
) (
    input  stamp_t           now,
    input  logic [SLOTS-1:0] used,
    input  stamp_t           stamps [SLOTS],
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    wide_t            tick_end;
    wide_t            horizon;
    logic [SLOTS-1:0] elig;

    assign tick_end = offset(now, LOG_TICK);
    assign horizon  = offset(now, LOG_HZ);

    for (genvar g = 0; g < SLOTS; g++) begin : g_elig
        assign elig[g] = used[g] &&
                         (({1'b0, stamps[g]} < tick_end) || ({1'b0, stamps[g]} >= horizon));
    end

    stamp_t best;
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (elig[i] && (!found_o || stamps[i] < best)) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                best    = stamps[i];
            end
        end
    end

endmodule

// File: rtl/act_emit.sv
module act_emit
    import act_rel_pkg::*;
#(
    parameter int LOG_HZ = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  stamp_t  now,
    input  logic    stall,
    input  logic    found,
    input  action_t cand,
    input  logic    cand_late,
    output logic    take_o,
    output kind_t   kind_o,
    output action_t act_o
);

    kind_t   kind_q;
    kind_t   kind_d;
    action_t act_q;
    logic    has_last_q;
    stamp_t  last_q;
    logic    hold;

    assign hold   = stall && (kind_q != K_IDLE);
    assign take_o = found && !hold;
    assign kind_d = classify(cand.stamp, cand_late, now, offset(now, LOG_HZ),
                             has_last_q, last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q     <= K_IDLE;
            act_q      <= '0;
            has_last_q <= 1'b0;
            last_q     <= '0;
        end else if (!hold) begin
            if (found) begin
                kind_q <= kind_d;
                act_q  <= cand;
                if (kind_d == K_ONTIME || kind_d == K_DELAYED) begin
                    has_last_q <= 1'b1;
                    last_q     <= cand.stamp;
                end
            end else begin
                kind_q <= K_IDLE;
                act_q  <= '0;
            end
        end
    end

    assign kind_o = kind_q;
    assign act_o  = act_q;

endmodule

// File: rtl/act_release.sv
module act_release
    import act_rel_pkg::*;
#(
    parameter int LOG_SLOTS = 2,
    parameter int LOG_TICK  = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TIME_W-1:0]  now_i,
    input  logic               in_valid_i,
    input  logic [TIME_W-1:0]  in_stamp_i,
    input  logic [EVT_W-1:0]   in_evt_i,
    input  logic [PRM_W-1:0]   in_prm_i,
    input  logic [TAG_W-1:0]   in_tag_i,
    input  logic               stall_i,
    output logic               out_valid_o,
    output logic               out_delayed_o,
    output logic               out_conflict_o,
    output logic               out_late_o,
    output logic               out_early_o,
    output logic [TIME_W-1:0]  out_stamp_o,
    output logic [EVT_W-1:0]   out_evt_o,
    output logic [PRM_W-1:0]   out_prm_o,
    output logic [TAG_W-1:0]   out_tag_o,
    output logic               overflow_o
);

    localparam int SLOTS  = 1 << LOG_SLOTS;
    localparam int IDX_W  = (LOG_SLOTS > 0) ? LOG_SLOTS : 1;
    localparam int LOG_HZ = LOG_SLOTS + LOG_TICK;

    action_t          in_act;
    action_t          acts [SLOTS];
    stamp_t           stamps [SLOTS];
    logic [SLOTS-1:0] used;
    logic [SLOTS-1:0] late;
    logic             full;
    logic             found;
    logic             take;
    logic [IDX_W-1:0] pick_idx;
    kind_t            kind;
    action_t          out_act;
    logic             ovf_q;

    assign in_act = '{stamp: in_stamp_i, evt: in_evt_i, prm: in_prm_i, tag: in_tag_i};

    act_store #(.SLOTS(SLOTS), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst(rst),
        .wr_en(in_valid_i), .wr_act(in_act), .wr_late(in_stamp_i < now_i),
        .take(take), .take_idx(pick_idx),
        .used_o(used), .acts_o(acts), .late_o(late), .full_o(full)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_stamp
        assign stamps[g] = acts[g].stamp;
    end

    act_pick #(.SLOTS(SLOTS), .IDX_W(IDX_W), .LOG_TICK(LOG_TICK), .LOG_HZ(LOG_HZ)) pick_i (
        .now(now_i), .used(used), .stamps(stamps),
        .found_o(found), .idx_o(pick_idx)
    );

    act_emit #(.LOG_HZ(LOG_HZ)) emit_i (
        .clk(clk), .rst(rst), .now(now_i), .stall(stall_i),
        .found(found), .cand(acts[pick_idx]), .cand_late(late[pick_idx]),
        .take_o(take), .kind_o(kind), .act_o(out_act)
    );

    always_ff @(posedge clk) begin
        if (rst) ovf_q <= 1'b0;
        else     ovf_q <= in_valid_i && full;
    end

    assign out_valid_o    = (kind == K_ONTIME);
    assign out_delayed_o  = (kind == K_DELAYED);
    assign out_conflict_o = (kind == K_CONFLICT);
    assign out_late_o     = (kind == K_LATE);
    assign out_early_o    = (kind == K_EARLY);
    assign out_stamp_o    = out_act.stamp;
    assign out_evt_o      = out_act.evt;
    assign out_prm_o      = out_act.prm;
    assign out_tag_o      = out_act.tag;
    assign overflow_o     = ovf_q;

endmodule

// File: rtl/act_release_chk.sv
module act_release_chk
    import act_rel_pkg::*;
#(
    parameter int LOG_TICK = 1
) (
    input logic               clk,
    input logic               rst,
    input logic [TIME_W-1:0]  now_i,
    input logic               in_valid_i,
    input logic               stall_i,
    input logic               out_valid_o,
    input logic               out_delayed_o,
    input logic               out_conflict_o,
    input logic               out_late_o,
    input logic               out_early_o,
    input logic [TIME_W-1:0]  out_stamp_o,
    input logic [EVT_W-1:0]   out_evt_o,
    input logic [PRM_W-1:0]   out_prm_o,
    input logic [TAG_W-1:0]   out_tag_o,
    input logic               overflow_o
);

    logic [4:0] flags;
    logic       hold;
    logic       fresh;
    stamp_t     prev_now;
    logic       prev_hold;
    logic       prev_inv;
    logic       has_last;
    stamp_t     last_t;

    assign flags = {out_valid_o, out_delayed_o, out_conflict_o, out_late_o, out_early_o};
    assign hold  = stall_i && (flags != '0);
    assign fresh = !prev_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_now  <= '0;
            prev_hold <= 1'b0;
            prev_inv  <= 1'b0;
            has_last  <= 1'b0;
            last_t    <= '0;
        end else begin
            prev_now  <= now_i;
            prev_hold <= hold;
            prev_inv  <= in_valid_i;
            if (fresh && (out_valid_o || out_delayed_o)) begin
                has_last <= 1'b1;
                last_t   <= out_stamp_o;
            end
        end
    end

    a_r6_one_flag: assert property (@(posedge clk) disable iff (rst) $onehot0(flags));

    a_r2_valid_window: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && fresh) |->
        (out_stamp_o >= prev_now && {1'b0, out_stamp_o} < offset(prev_now, LOG_TICK)));

    a_r5_late_in_past: assert property (@(posedge clk) disable iff (rst)
        ((out_late_o || out_delayed_o) && fresh) |-> (out_stamp_o < prev_now));

    a_r3_conflict_repeat: assert property (@(posedge clk) disable iff (rst)
        (out_conflict_o && fresh) |-> (has_last && out_stamp_o == last_t));

    a_r4_monotonic: assert property (@(posedge clk) disable iff (rst)
        ((out_valid_o || out_delayed_o) && fresh && has_last) |-> (out_stamp_o > last_t));

    a_r7_overflow_cause: assert property (@(posedge clk) disable iff (rst)
        overflow_o |-> prev_inv);

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable({flags, out_stamp_o, out_evt_o, out_prm_o, out_tag_o}));

endmodule

bind act_release act_release_chk #(.LOG_TICK(LOG_TICK)) chk_i (.*);

// File: tb/act_release_tb_top.sv
module act_release_tb_top;
    import act_rel_pkg::*;

    localparam int LOG_SLOTS = 2;
    localparam int LOG_TICK  = 1;
    localparam int SLOTS     = 1 << LOG_SLOTS;
    localparam int TICK      = 1 << LOG_TICK;
    localparam int HZ        = 1 << (LOG_SLOTS + LOG_TICK);

    logic clk = 0;
    logic rst = 1;
    logic [31:0] now_i = 0;
    logic in_valid_i = 0;
    logic [31:0] in_stamp_i = 0;
    logic [7:0]  in_evt_i = 0;
    logic [15:0] in_prm_i = 0;
    logic [7:0]  in_tag_i = 0;
    logic stall_i = 0;
    logic out_valid_o, out_delayed_o, out_conflict_o, out_late_o, out_early_o;
    logic [31:0] out_stamp_o;
    logic [7:0]  out_evt_o;
    logic [15:0] out_prm_o;
    logic [7:0]  out_tag_o;
    logic overflow_o;

    act_release #(.LOG_SLOTS(LOG_SLOTS), .LOG_TICK(LOG_TICK)) dut_i (.*);

    always #4 clk = ~clk;

    typedef struct {
        int unsigned t;
        int unsigned ev, pa, tg;
        bit arrl;
    } ent_t;

    ent_t q[$];
    int unsigned e_kind, e_t, e_ev, e_pa, e_tg;
    bit e_ovf, has_last;
    int unsigned last_t, now;
    int vecs = 0, bad = 0;
    int seen [6];
    bit done = 0;
    bit dut_hold_prev = 0;
    bit dut_has_last = 0;
    int unsigned dut_last = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural model: one clock edge
    task automatic model_step(bit inv, int unsigned it, int unsigned iev, int unsigned ipa,
                              int unsigned itg, bit st);
        bit hold = st && (e_kind != 0);
        bit full = (q.size() == SLOTS);
        if (!hold) begin
            int best = -1;
            foreach (q[i]) begin
                bit el = (q[i].t < now + TICK) || (q[i].t >= now + HZ);
                if (el && (best < 0 || q[i].t < q[best].t)) best = i;
            end
            if (best >= 0) begin
                ent_t x = q[best];
                q.delete(best);
                if (x.arrl || (has_last && x.t < last_t)) e_kind = 4;
                else if (x.t >= now + HZ) e_kind = 5;
                else if (has_last && x.t == last_t) e_kind = 3;
                else if (x.t >= now) e_kind = 1;
                else e_kind = 2;
                if (e_kind == 1 || e_kind == 2) begin has_last = 1; last_t = x.t; end
                e_t = x.t; e_ev = x.ev; e_pa = x.pa; e_tg = x.tg;
                seen[e_kind]++;
            end else begin
                e_kind = 0; e_t = 0; e_ev = 0; e_pa = 0; e_tg = 0;
            end
        end
        e_ovf = inv && full;
        if (e_ovf) seen[0]++;
        if (inv && !full) q.push_back('{t: it, ev: iev, pa: ipa, tg: itg, arrl: (it < now)});
    endtask

    task automatic compare();
        int unsigned k;
        k = out_valid_o ? 1 : out_delayed_o ? 2 : out_conflict_o ? 3 : out_late_o ? 4 : out_early_o ? 5 : 0;
        chk("R6", "flag count", $countones({out_valid_o, out_delayed_o, out_conflict_o, out_late_o, out_early_o}) > 1, 0);
        chk("R2", "on-time flag", out_valid_o, e_kind == 1);
        chk("R4", "delayed flag", out_delayed_o, e_kind == 2);
        chk("R3", "conflict flag", out_conflict_o, e_kind == 3);
        chk("R5", "late flag", out_late_o, e_kind == 4);
        chk("R6", "early flag", out_early_o, e_kind == 5);
        chk("R9", "timestamp", out_stamp_o, e_t);
        chk("R1", "event", out_evt_o, e_ev);
        chk("R1", "parameter", out_prm_o, e_pa);
        chk("R1", "tag", out_tag_o, e_tg);
        chk("R7", "overflow", overflow_o, e_ovf);
        if (!dut_hold_prev && (k == 1 || k == 2)) begin
            if (dut_has_last) chk("R4", "monotonic order", out_stamp_o > dut_last, 1);
            dut_has_last = 1;
            dut_last = out_stamp_o;
        end
    endtask

    task automatic step(bit inv, int unsigned it, bit st);
        int unsigned ev = $urandom_range(255), pa = $urandom_range(65535), tg = $urandom_range(255);
        now_i = now; in_valid_i = inv; in_stamp_i = it;
        in_evt_i = inv ? ev[7:0] : 0; in_prm_i = inv ? pa[15:0] : 0; in_tag_i = inv ? tg[7:0] : 0;
        stall_i = st;
        model_step(inv, it, in_evt_i, in_prm_i, in_tag_i, st);
        @(posedge clk);
        @(negedge clk);
        dut_hold_prev = st && (out_valid_o | out_delayed_o | out_conflict_o | out_late_o | out_early_o);
        compare();
        // hold status seen by the next edge is computed from the outputs now present
        now += TICK;
    endtask

    function automatic bit taken(int unsigned t);
        foreach (q[i]) if (q[i].t == t) return 1;
        return 0;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R10: reset state
        chk("R10", "flags after reset", {out_valid_o, out_delayed_o, out_conflict_o, out_late_o, out_early_o}, 0);
        chk("R10", "stamp after reset", out_stamp_o, 0);
        chk("R10", "overflow after reset", overflow_o, 0);
        now = 100;
        // R1/R2: single action inside next tick
        step(1, now + 3, 0); step(0, 0, 0); step(0, 0, 0);
        // R3: two actions with one timestamp
        step(1, now + 5, 0); step(1, now + 3, 0);
        repeat (4) step(0, 0, 0);
        // R5: overdue at arrival
        step(1, now - 1, 0); step(0, 0, 0);
        // R6: beyond horizon
        step(1, now + 20, 0); step(0, 0, 0);
        // R8 + R4: stall holds an on-time output while another falls due
        step(1, now + 3, 0);
        step(1, now + 3, 0);
        step(0, 0, 1);
        step(0, 0, 0);
        repeat (3) step(0, 0, 0);
        // R7: fill the store under a held output, then one more
        step(1, now + 3, 0);
        step(0, 0, 0);
        for (int i = 0; i < SLOTS + 1; i++) step(1, now + 40 + i, 1);
        step(0, 0, 1);
        repeat (8) step(0, 0, 0);
        // random mix
        for (int n = 0; n < 600; n++) begin
            bit inv = ($urandom_range(99) < 60);
            int unsigned t = now + $urandom_range(15) - 3;
            while (taken(t)) t++;
            step(inv, t, $urandom_range(99) < 25);
        end
        repeat (40) step(0, 0, 0);
        // R9: exactly once — nothing left behind
        chk("R9", "store drained", q.size(), 0);
        chk("R2", "on-time seen", seen[1] > 0, 1);
        chk("R4", "delayed seen", seen[2] > 0, 1);
        chk("R3", "conflict seen", seen[3] > 0, 1);
        chk("R5", "late seen", seen[4] > 0, 1);
        chk("R6", "early seen", seen[5] > 0, 1);
        chk("R7", "overflow seen", seen[0] > 0, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vecs++; bad++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

endmodule